// File: doc/BRIEF.md
# FIFO Watermark Interrupt and DMA Request Unit

This block sits beside a pair of 16-byte data FIFOs in a two-wire serial bus controller, one FIFO on the master side and one on the slave side. It turns FIFO occupancy, transfer direction and protocol event pulses into a seven-source interrupt scheme and four DMA request lines. The FIFO storage, the bus protocol engine and the DMA controller are outside this block. The block only sees level counts, direction flags, watermark values and single-cycle event strobes.

Each source has a raw status bit. Event pulses set it and software clears it by writing ones. A mask register selects which raw bits reach the single interrupt output, and a masked view is readable. Each FIFO side has a watermark request whose comparison flips with the direction of the transfer. The DMA single and burst requests for each side follow fixed byte thresholds on either the bytes held or the bytes free. Each side also keeps sticky overflow and underrun flags, which only a FIFO clear pulse removes.

Top module: `fifo_irq_dma_req`

## Requirements
- R1: Raw status bit positions are 0 command success, 1 command error, 2 FIFO error, 3 bus busy, 4 master watermark request, 5 slave watermark request, 6 slave request. A pulse on an event input sets its bit on the next clock edge. Bit 2 is set by any overflow or underrun pulse of either FIFO.
- R2: A write to the raw status register (address 1) clears every bit written as 1. Bits written as 0 keep their value.
- R3: If a set condition and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R4: A write to the mask register (address 0) clears the raw bit of every mask bit that goes from 0 to 1. A mask bit that stays 1 leaves its raw bit alone.
- R5: Address 2 reads the raw status AND the mask. The interrupt output goes high one cycle after any masked bit is set and falls one cycle after none is.
- R6: A side that transmits (direction input 0) requests while its level is below its 4-bit watermark. A side that receives (direction input 1) requests while its level is above it. Levels run from 0 to 16.
- R7: A receiving side raises single when it holds more than 1 byte and burst when it holds more than 4 bytes. A transmitting side applies the same limits to its free bytes, which are 16 minus the level. The request lines are registered.
- R8: The DMA enable register (address 3) holds bit 0 master single, bit 1 master burst, bit 2 slave single and bit 3 slave burst. A request line stays low while its enable bit is clear.
- R9: The overflow and underrun flags of each FIFO are sticky. They are cleared only by that FIFO's clear pulse, which wins over an error pulse in the same cycle.
- R10: After reset, the raw status, mask, DMA enables, sticky flags, interrupt, DMA lines and read data are all zero.
- R11: The read data is registered. It shows the register selected by the address one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_cmd_ok | input | 1 | Command finished successfully pulse |
| evt_cmd_err | input | 1 | Command finished with error pulse |
| evt_bus_busy | input | 1 | Bus lost to another master pulse |
| evt_slv_req | input | 1 | Slave addressed pulse |
| m_level | input | 5 | Master FIFO level, 0 to 16 |
| m_dir_rx | input | 1 | Master side receives (1) or transmits (0) |
| m_wm | input | 4 | Master watermark |
| m_ovf_evt | input | 1 | Master FIFO overflow pulse |
| m_udr_evt | input | 1 | Master FIFO underrun pulse |
| m_clr | input | 1 | Master FIFO clear pulse |
| s_level | input | 5 | Slave FIFO level, 0 to 16 |
| s_dir_rx | input | 1 | Slave side receives (1) or transmits (0) |
| s_wm | input | 4 | Slave watermark |
| s_ovf_evt | input | 1 | Slave FIFO overflow pulse |
| s_udr_evt | input | 1 | Slave FIFO underrun pulse |
| s_clr | input | 1 | Slave FIFO clear pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 7 | Register write data |
| reg_rdata | output | 7 | Registered read data |
| irq | output | 1 | Combined interrupt |
| m_dma_single | output | 1 | Master DMA single request |
| m_dma_burst | output | 1 | Master DMA burst request |
| s_dma_single | output | 1 | Slave DMA single request |
| s_dma_burst | output | 1 | Slave DMA burst request |
| m_ovf | output | 1 | Master overflow sticky flag |
| m_udr | output | 1 | Master underrun sticky flag |
| s_ovf | output | 1 | Slave overflow sticky flag |
| s_udr | output | 1 | Slave underrun sticky flag |

## Verification
The bench walks the watermark comparison and the DMA thresholds across their edges in both directions: level equal to the watermark, one free byte, exactly four bytes free or held, and a full FIFO. An off-by-one compare or a missing direction swap shows up there as a request that appears or vanishes at the wrong level. It also drives a write-1 clear in the same cycle as an event, so a design that let the clear win would drop the event. It rewrites a mask bit that is already 1, which a design that cleared on every mask write would wrongly clear. Finally it pulses a FIFO clear together with an error pulse, which shows whether the sticky flags give the clear priority.

// File: rtl/fidr_pkg.sv
package fidr_pkg;
  localparam int NSRC  = 7;
  localparam int NDMA  = 4;
  localparam int ADR_W = 2;

  localparam int SRC_CMD_OK  = 0;
  localparam int SRC_CMD_ERR = 1;
  localparam int SRC_FIFOERR = 2;
  localparam int SRC_BUSBUSY = 3;
  localparam int SRC_M_WM    = 4;
  localparam int SRC_S_WM    = 5;
  localparam int SRC_SLVREQ  = 6;

  localparam logic [ADR_W-1:0] ADR_MASK = 2'd0;
  localparam logic [ADR_W-1:0] ADR_RAW  = 2'd1;
  localparam logic [ADR_W-1:0] ADR_MSKD = 2'd2;
  localparam logic [ADR_W-1:0] ADR_DMA  = 2'd3;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/fidr_fifo_side.sv
module fidr_fifo_side #(
  parameter int DEPTH     = 16,
  parameter int LVL_W     = 5,
  parameter int WM_W      = 4,
  parameter int SINGLE_TH = 1,
  parameter int BURST_TH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic             dir_rx,
  input  logic [WM_W-1:0]  wm,
  input  logic             ovf_evt,
  input  logic             udr_evt,
  input  logic             clr,
  input  logic             en_single,
  input  logic             en_burst,
  output logic             wm_req,
  output logic             err_evt,
  output logic             dma_single,
  output logic             dma_burst,
  output logic             ovf_flag,
  output logic             udr_flag
);
  localparam logic [LVL_W-1:0] DEPTH_L  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] SINGLE_L = LVL_W'(SINGLE_TH);
  localparam logic [LVL_W-1:0] BURST_L  = LVL_W'(BURST_TH);

  logic [LVL_W-1:0] lvl_c;
  logic [LVL_W-1:0] free_c;
  logic [LVL_W-1:0] wm_x;
  logic [LVL_W-1:0] occ_sel;

  always_comb begin
    lvl_c   = (level > DEPTH_L) ? DEPTH_L : level;
    free_c  = DEPTH_L - lvl_c;
    wm_x    = LVL_W'(wm);
    wm_req  = dir_rx ? (lvl_c > wm_x) : (lvl_c < wm_x);
    occ_sel = dir_rx ? lvl_c : free_c;
    err_evt = ovf_evt | udr_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dma_single <= 1'b0;
      dma_burst  <= 1'b0;
    end else begin
      dma_single <= en_single & (occ_sel > SINGLE_L);
      dma_burst  <= en_burst  & (occ_sel > BURST_L);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ovf_flag <= 1'b0;
      udr_flag <= 1'b0;
    end else begin
      if (ovf_evt) ovf_flag <= 1'b1;
      if (udr_evt) udr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/fidr_irq_regs.sv
module fidr_irq_regs
  import fidr_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int ND = NDMA,
  parameter int AW = ADR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] src_set,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [NS-1:0] reg_wdata,
  output logic [NS-1:0] raw,
  output logic [NS-1:0] mask,
  output logic [ND-1:0] dma_en,
  output logic [NS-1:0] rdata
);
  logic [NS-1:0] raw_q, raw_d, mask_q, mask_d, rise, w1c;
  logic [ND-1:0] dma_en_q, dma_en_d;
  logic [NS-1:0] rd_mux;

  always_comb begin
    mask_d   = (reg_wr && reg_addr == ADR_MASK) ? reg_wdata : mask_q;
    rise     = mask_d & ~mask_q;
    w1c      = (reg_wr && reg_addr == ADR_RAW) ? reg_wdata : '0;
    raw_d    = (raw_q & ~w1c & ~rise) | src_set;
    dma_en_d = (reg_wr && reg_addr == ADR_DMA) ? reg_wdata[ND-1:0] : dma_en_q;
    unique case (reg_addr)
      ADR_MASK: rd_mux = mask_q;
      ADR_RAW:  rd_mux = raw_q;
      ADR_MSKD: rd_mux = raw_q & mask_q;
      default:  rd_mux = NS'(dma_en_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      mask_q   <= '0;
      dma_en_q <= '0;
      rdata    <= '0;
    end else begin
      raw_q    <= raw_d;
      mask_q   <= mask_d;
      dma_en_q <= dma_en_d;
      rdata    <= rd_mux;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign dma_en = dma_en_q;
endmodule

// File: rtl/fifo_irq_dma_req.sv
module fifo_irq_dma_req
  import fidr_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WM_W      = 4,
  parameter int SINGLE_TH = 1,
  parameter int BURST_TH  = 4,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_cmd_ok,
  input  logic             evt_cmd_err,
  input  logic             evt_bus_busy,
  input  logic             evt_slv_req,
  input  logic [LVL_W-1:0] m_level,
  input  logic             m_dir_rx,
  input  logic [WM_W-1:0]  m_wm,
  input  logic             m_ovf_evt,
  input  logic             m_udr_evt,
  input  logic             m_clr,
  input  logic [LVL_W-1:0] s_level,
  input  logic             s_dir_rx,
  input  logic [WM_W-1:0]  s_wm,
  input  logic             s_ovf_evt,
  input  logic             s_udr_evt,
  input  logic             s_clr,
  input  logic             reg_wr,
  input  logic [ADR_W-1:0] reg_addr,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  output logic             irq,
  output logic             m_dma_single,
  output logic             m_dma_burst,
  output logic             s_dma_single,
  output logic             s_dma_burst,
  output logic             m_ovf,
  output logic             m_udr,
  output logic             s_ovf,
  output logic             s_udr
);
  localparam int NSIDE = 2;

  logic [LVL_W-1:0] lvl_a [NSIDE];
  logic [WM_W-1:0]  wm_a  [NSIDE];
  logic [NSIDE-1:0] dir_a, ovfe_a, udre_a, clr_a;
  logic [NSIDE-1:0] wmreq_a, erre_a, dsing_a, dbur_a, ovf_a, udr_a;
  logic [NSRC-1:0]  src_set, raw_w, mask_w;
  logic [NDMA-1:0]  dma_en_w;

  always_comb begin
    lvl_a[0] = m_level;  lvl_a[1] = s_level;
    wm_a[0]  = m_wm;     wm_a[1]  = s_wm;
    dir_a    = {s_dir_rx,  m_dir_rx};
    ovfe_a   = {s_ovf_evt, m_ovf_evt};
    udre_a   = {s_udr_evt, m_udr_evt};
    clr_a    = {s_clr,     m_clr};
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    fidr_fifo_side #(
      .DEPTH(DEPTH), .LVL_W(LVL_W), .WM_W(WM_W),
      .SINGLE_TH(SINGLE_TH), .BURST_TH(BURST_TH)
    ) u_side (
      .clk(clk), .rst(rst),
      .level(lvl_a[g]), .dir_rx(dir_a[g]), .wm(wm_a[g]),
      .ovf_evt(ovfe_a[g]), .udr_evt(udre_a[g]), .clr(clr_a[g]),
      .en_single(dma_en_w[2*g]), .en_burst(dma_en_w[2*g+1]),
      .wm_req(wmreq_a[g]), .err_evt(erre_a[g]),
      .dma_single(dsing_a[g]), .dma_burst(dbur_a[g]),
      .ovf_flag(ovf_a[g]), .udr_flag(udr_a[g])
    );
  end

  always_comb begin
    src_set = '0;
    src_set[SRC_CMD_OK]  = evt_cmd_ok;
    src_set[SRC_CMD_ERR] = evt_cmd_err;
    src_set[SRC_FIFOERR] = |erre_a;
    src_set[SRC_BUSBUSY] = evt_bus_busy;
    src_set[SRC_M_WM]    = wmreq_a[0];
    src_set[SRC_S_WM]    = wmreq_a[1];
    src_set[SRC_SLVREQ]  = evt_slv_req;
  end

  fidr_irq_regs u_regs (
    .clk(clk), .rst(rst), .src_set(src_set),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .raw(raw_w), .mask(mask_w), .dma_en(dma_en_w), .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw_w & mask_w);
  end

  assign m_dma_single = dsing_a[0];
  assign m_dma_burst  = dbur_a[0];
  assign s_dma_single = dsing_a[1];
  assign s_dma_burst  = dbur_a[1];
  assign m_ovf = ovf_a[0];
  assign m_udr = udr_a[0];
  assign s_ovf = ovf_a[1];
  assign s_udr = udr_a[1];
endmodule

// File: rtl/fidr_chk.sv
module fidr_chk
  import fidr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             evt_cmd_ok,
  input logic             evt_cmd_err,
  input logic             reg_wr,
  input logic [ADR_W-1:0] reg_addr,
  input logic [NSRC-1:0]  reg_wdata,
  input logic [NSRC-1:0]  raw,
  input logic [NSRC-1:0]  mask,
  input logic [NDMA-1:0]  dma_en,
  input logic             irq,
  input logic             m_dma_single,
  input logic             m_clr,
  input logic             m_ovf_evt,
  input logic             m_ovf
);
  p_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
    evt_cmd_ok |=> raw[SRC_CMD_OK]);

  p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_RAW && reg_wdata[SRC_CMD_OK] && !evt_cmd_ok)
    |=> !raw[SRC_CMD_OK]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_cmd_ok && reg_wr && reg_addr == ADR_RAW) |=> raw[SRC_CMD_OK]);

  p_rise_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_MASK && reg_wdata[SRC_CMD_ERR] &&
     !mask[SRC_CMD_ERR] && !evt_cmd_err) |=> !raw[SRC_CMD_ERR]);

  p_irq_follow_r5: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(raw & mask)));

  p_dma_gate_r8: assert property (@(posedge clk) disable iff (rst)
    m_dma_single |-> $past(dma_en[0]));

  p_sticky_clr_r9: assert property (@(posedge clk) disable iff (rst)
    m_clr |=> !m_ovf);

  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ((m_ovf || m_ovf_evt) && !m_clr) |=> m_ovf);
endmodule

bind fifo_irq_dma_req fidr_chk u_chk (
  .clk(clk), .rst(rst), .evt_cmd_ok(evt_cmd_ok), .evt_cmd_err(evt_cmd_err),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .raw(raw_w), .mask(mask_w), .dma_en(dma_en_w), .irq(irq),
  .m_dma_single(m_dma_single), .m_clr(m_clr), .m_ovf_evt(m_ovf_evt),
  .m_ovf(m_ovf)
);

// File: tb/sim_fifo_irq_dma_req.sv
module sim_fifo_irq_dma_req;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic evt_cmd_ok = 0, evt_cmd_err = 0, evt_bus_busy = 0, evt_slv_req = 0;
  logic [4:0] m_level = 0, s_level = 0;
  logic m_dir_rx = 0, s_dir_rx = 0;
  logic [3:0] m_wm = 0, s_wm = 0;
  logic m_ovf_evt = 0, m_udr_evt = 0, m_clr = 0;
  logic s_ovf_evt = 0, s_udr_evt = 0, s_clr = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [6:0] reg_wdata = 0;
  logic [6:0] reg_rdata;
  logic irq, m_dma_single, m_dma_burst, s_dma_single, s_dma_burst;
  logic m_ovf, m_udr, s_ovf, s_udr;

  fifo_irq_dma_req u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // {dir_rx, level[4:0], wm[3:0], req, single, burst}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 5'd0,  4'd4,  1'b1, 1'b1, 1'b1},
    {1'b0, 5'd4,  4'd4,  1'b0, 1'b1, 1'b1},
    {1'b0, 5'd12, 4'd4,  1'b0, 1'b1, 1'b0},
    {1'b0, 5'd15, 4'd15, 1'b0, 1'b0, 1'b0},
    {1'b0, 5'd14, 4'd15, 1'b1, 1'b1, 1'b0},
    {1'b1, 5'd5,  4'd4,  1'b1, 1'b1, 1'b1},
    {1'b1, 5'd4,  4'd4,  1'b0, 1'b1, 1'b0},
    {1'b1, 5'd1,  4'd0,  1'b1, 1'b0, 1'b0},
    {1'b1, 5'd0,  4'd0,  1'b0, 1'b0, 1'b0},
    {1'b1, 5'd16, 4'd15, 1'b1, 1'b1, 1'b1},
    {1'b1, 5'd2,  4'd3,  1'b0, 1'b1, 1'b0},
    {1'b0, 5'd16, 4'd0,  1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [6:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic neutral();
    m_dir_rx = 0; s_dir_rx = 0; m_level = 8; s_level = 8; m_wm = 8; s_wm = 8;
    tick();
    wr(2'd1, 7'h7F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [6:0] d;
    tick(3);
    rst = 0;
    tick();
    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 dma", {m_dma_single, m_dma_burst, s_dma_single, s_dma_burst}, 0);
    chk("R10 sticky", {m_ovf, m_udr, s_ovf, s_udr}, 0);
    rd(2'd0, d); chk("R10 mask", d, 0);
    rd(2'd3, d); chk("R10 dma_en", d, 0);

    // R6 / R7 table walk with all DMA enables on
    wr(2'd3, 7'h0F);
    for (int i = 0; i < 12; i++) begin
      m_dir_rx = VEC[i][12]; s_dir_rx = VEC[i][12];
      m_level = VEC[i][11:7]; s_level = VEC[i][11:7];
      m_wm = VEC[i][6:3]; s_wm = VEC[i][6:3];
      tick();
      wr(2'd1, 7'h30);
      rd(2'd1, d);
      chk($sformatf("R6 master req v%0d", i), d[4], VEC[i][2]);
      chk($sformatf("R6 slave req v%0d", i), d[5], VEC[i][2]);
      chk($sformatf("R7 m single v%0d", i), m_dma_single, VEC[i][1]);
      chk($sformatf("R7 m burst v%0d", i), m_dma_burst, VEC[i][0]);
      chk($sformatf("R7 s single v%0d", i), s_dma_single, VEC[i][1]);
      chk($sformatf("R7 s burst v%0d", i), s_dma_burst, VEC[i][0]);
    end

    neutral();
    rd(2'd1, d); chk("R2 all cleared", d, 7'h00);

    // R1 event pulses
    evt_cmd_ok = 1; tick(); evt_cmd_ok = 0;
    evt_slv_req = 1; tick(); evt_slv_req = 0;
    rd(2'd1, d); chk("R1 raw bits 0 and 6", d, 7'h41);
    tick(); chk("R5 irq stays low when masked off", irq, 0);

    // R2 write zero has no effect, write one clears
    wr(2'd1, 7'h00);
    rd(2'd1, d); chk("R2 write zero", d, 7'h41);
    wr(2'd1, 7'h01);
    rd(2'd1, d); chk("R2 write one", d, 7'h40);

    // R4 mask rise clears
    wr(2'd0, 7'h40);
    rd(2'd1, d); chk("R4 rise clears raw", d, 7'h00);
    evt_slv_req = 1; tick(); evt_slv_req = 0;
    tick(2);
    chk("R5 irq high", irq, 1);
    rd(2'd2, d); chk("R5 masked view", d, 7'h40);
    // R11: address change shows only after the next edge
    reg_addr = 2'd3; #1;
    chk("R11 rdata unchanged before edge", reg_rdata, 7'h40);
    tick(); chk("R11 rdata after edge", reg_rdata, 7'h0F);
    wr(2'd0, 7'h40);
    rd(2'd1, d); chk("R4 mask kept at one keeps raw", d, 7'h40);
    wr(2'd1, 7'h40);
    tick(2);
    chk("R5 irq falls after clear", irq, 0);

    // R3 set wins over clear
    evt_bus_busy = 1; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 7'h08;
    tick();
    evt_bus_busy = 0; reg_wr = 0; reg_wdata = 0;
    rd(2'd1, d); chk("R3 set wins", d, 7'h08);

    // R9 sticky flags and R1 FIFO error source
    m_ovf_evt = 1; tick(); m_ovf_evt = 0;
    tick();
    chk("R9 m_ovf set", m_ovf, 1);
    rd(2'd1, d); chk("R1 fifo error bit", d, 7'h0C);
    wr(2'd1, 7'h04);
    chk("R9 m_ovf survives status clear", m_ovf, 1);
    m_clr = 1; tick(); m_clr = 0;
    chk("R9 m_ovf cleared by fifo clear", m_ovf, 0);
    s_udr_evt = 1; tick(); s_udr_evt = 0;
    chk("R9 s_udr set", s_udr, 1);
    s_udr_evt = 1; s_clr = 1; tick(); s_udr_evt = 0; s_clr = 0;
    chk("R9 clear beats error pulse", s_udr, 0);

    // R8 gating
    wr(2'd3, 7'h00);
    m_level = 0; s_level = 0; m_wm = 0; s_wm = 0;
    tick(3);
    chk("R8 all gated low", {m_dma_single, m_dma_burst, s_dma_single, s_dma_burst}, 4'b0000);
    wr(2'd3, 7'h05);
    tick();
    chk("R8 singles only", {m_dma_single, m_dma_burst, s_dma_single, s_dma_burst}, 4'b1010);

    // R5 level source through mask
    m_wm = 4;
    tick();
    wr(2'd0, 7'h10);
    tick(2);
    chk("R5 watermark irq", irq, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule